// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-programmed SPI master for serial flash parts. Software loads a command word (an opcode plus a 24-bit flash address), an optional data word, and then a control word that carries two byte counts and a start bit. One frame then runs with chip select held low for its whole length. The transmit bytes go out first: the opcode, then the address bytes, then the data bytes. The receive bytes are then clocked in and placed into the data word.

A busy flag in the control word is set while a frame runs. Software polls it and reads the data word back once it clears. Only clock mode 0 with a single attached device is provided. The serial clock is the system clock divided by `2*HALF_DIV`.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset the chip select is high, SCLK and MOSI are low, busy reads 0, and the command, data and control words read 0.
- R2: The word address selects a register. Address 0 is the command word: opcode in bits 7:0 and flash address in bits 31:8. Address 1 is the 32-bit data word. Address 2 is the control word: transmit count in bits 3:0, receive count in bits 7:4, start in bit 8 (it always reads 0) and busy in bit 9. Address 3 reads 0. Writes take effect at the clock edge and read back unchanged.
- R3: The transmit stream is built as follows. Byte 0 is the opcode. Bytes 1 to 3 are the address from its most significant byte down (command bits 31:24, then 23:16, then 15:8). Bytes 4 to 7 are the data word, with bits 7:0 first. Each byte is sent most significant bit first. Exactly transmit-count bytes are sent, and MOSI is low whenever chip select is high.
- R4: A transmit count above 8 is stored and used as 8. A receive count above 4 is stored and used as 4.
- R5: Receive bytes follow the transmit bytes. MISO is sampled on SCLK rising edges, most significant bit first, and MOSI is held low during them. Received byte k is written to data bits 8k+7:8k. Data lanes beyond the receive count keep their previous value.
- R6: Chip select stays low for the whole frame, and the frame has exactly 8*(transmit count + receive count) SCLK rising edges.
- R7: Busy reads 1 from the cycle after the start write, with chip select low in that same cycle. Busy falls one clock cycle after chip select returns high.
- R8: SCLK idles low. While a frame runs, each SCLK half period lasts HALF_DIV clock cycles, so rising edges are 2*HALF_DIV cycles apart.
- R9: Register writes made while busy is 1 are ignored, including a second start.
- R10: A start with both counts zero starts no frame: chip select stays high and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address for writes |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register word address for reads |
| rd_data | output | 32 | Register read data (combinational) |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the engine with HALF_DIV = 3. With an odd divider of more than one cycle, the half-period counter has to wrap at a value that is not a power of two, and the rising-edge spacing of 30 ns can only be met by that wrap. The bench also drives counts of 15 and 9 to reach the clamp limits. It runs a full 12-byte frame that uses every transmit and receive lane, and a short receive that must leave the upper data lanes untouched.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
package spi_eng_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 4;
  localparam int MAX_TX = 8;
  localparam int MAX_RX = 4;
  localparam int BIT_W  = $clog2((MAX_TX + MAX_RX) * 8 + 1);

  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_DATA = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;

  localparam int CTRL_TX_LSB    = 0;
  localparam int CTRL_RX_LSB    = 4;
  localparam int CTRL_START_BIT = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} eng_state_t;

  // saturate a count field at its limit
  function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] v, input int lim);
    if (int'(v) > lim) return CNT_W'(lim);
    return v;
  endfunction

  // byte idx of the outgoing stream: opcode, address high..low, data low..high
  function automatic logic [7:0] frame_tx_byte(input logic [WORD_W-1:0] cmd,
                                               input logic [WORD_W-1:0] dat,
                                               input logic [CNT_W-1:0] idx);
    case (idx)
      4'd0:    return cmd[7:0];
      4'd1:    return cmd[31:24];
      4'd2:    return cmd[23:16];
      4'd3:    return cmd[15:8];
      4'd4:    return dat[7:0];
      4'd5:    return dat[15:8];
      4'd6:    return dat[23:16];
      4'd7:    return dat[31:24];
      default: return 8'h00;
    endcase
  endfunction

  // total serial bits of a frame
  function automatic logic [BIT_W-1:0] frame_bits(input logic [CNT_W-1:0] tx,
                                                  input logic [CNT_W-1:0] rx);
    return BIT_W'((int'(tx) + int'(rx)) * 8);
  endfunction
endpackage

// File: rtl/spi_eng_regs.sv
`timescale 1ns/1ps
module spi_eng_regs
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              busy,
  input  logic              rx_we,
  input  logic [1:0]        rx_lane,
  input  logic [7:0]        rx_byte,
  output logic [WORD_W-1:0] cmd_q,
  output logic [WORD_W-1:0] data_q,
  output logic [CNT_W-1:0]  tx_cnt,
  output logic [CNT_W-1:0]  rx_cnt,
  output logic              go
);
  logic             wr_ok;
  logic [CNT_W-1:0] tx_new;
  logic [CNT_W-1:0] rx_new;

  assign wr_ok  = wr_en && !busy;
  assign tx_new = clamp_cnt(wr_data[CTRL_TX_LSB +: CNT_W], MAX_TX);
  assign rx_new = clamp_cnt(wr_data[CTRL_RX_LSB +: CNT_W], MAX_RX);
  assign go     = wr_ok && (wr_addr == RA_CTRL) && wr_data[CTRL_START_BIT] &&
                  ((tx_new != '0) || (rx_new != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      tx_cnt <= '0;
      rx_cnt <= '0;
    end else if (wr_ok) begin
      case (wr_addr)
        RA_CMD:  cmd_q  <= wr_data;
        RA_DATA: data_q <= wr_data;
        RA_CTRL: begin
          tx_cnt <= tx_new;
          rx_cnt <= rx_new;
        end
        default: ;
      endcase
    end else if (rx_we) begin
      data_q[{rx_lane, 3'b000} +: 8] <= rx_byte;
    end
  end

  always_comb begin
    case (rd_addr)
      RA_CMD:  rd_data = cmd_q;
      RA_DATA: rd_data = data_q;
      RA_CTRL: rd_data = {22'd0, busy, 1'b0, rx_cnt, tx_cnt};
      default: rd_data = '0;
    endcase
  end

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(cmd_q) && $stable(tx_cnt) && $stable(rx_cnt)));
endmodule

// File: rtl/spi_eng_sclk.sv
`timescale 1ns/1ps
module spi_eng_sclk #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DIV_W-1:0] div_q;
  logic             half_end;

  assign half_end = (div_q == DIV_W'(HALF_DIV - 1));
  assign rise_evt = run && half_end && !sck;
  assign fall_evt = run && half_end && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sck   <= 1'b0;
    end else if (!run) begin
      div_q <= '0;
      sck   <= 1'b0;
    end else if (half_end) begin
      div_q <= '0;
      sck   <= !sck;
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/spi_eng_frame.sv
`timescale 1ns/1ps
module spi_eng_frame
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CNT_W-1:0]  tx_cnt,
  input  logic [CNT_W-1:0]  rx_cnt,
  input  logic [WORD_W-1:0] cmd_q,
  input  logic [WORD_W-1:0] data_q,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              miso,
  output logic              run,
  output logic              busy,
  output logic              cs_n,
  output logic              mosi,
  output logic              rx_we,
  output logic [1:0]        rx_lane,
  output logic [7:0]        rx_byte
);
  eng_state_t       st_q;
  logic [BIT_W-1:0] bit_q;
  logic [6:0]       rx_sh_q;
  logic [CNT_W-1:0] byte_idx;
  logic [2:0]       bit_in;
  logic             in_tx;
  logic [BIT_W-1:0] last_bit;
  logic [7:0]       cur_tx;

  assign byte_idx = CNT_W'(bit_q >> 3);
  assign bit_in   = bit_q[2:0];
  assign in_tx    = byte_idx < tx_cnt;
  assign last_bit = frame_bits(tx_cnt, rx_cnt) - BIT_W'(1);
  assign cur_tx   = frame_tx_byte(cmd_q, data_q, byte_idx);

  assign run     = (st_q == ST_SHIFT);
  assign busy    = (st_q != ST_IDLE);
  assign cs_n    = !run;
  assign mosi    = run && in_tx && cur_tx[3'd7 - bit_in];
  assign rx_byte = {rx_sh_q, miso};
  assign rx_we   = rise_evt && !in_tx && (bit_in == 3'd7);
  assign rx_lane = 2'(byte_idx - tx_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      bit_q   <= '0;
      rx_sh_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (go) begin
            st_q  <= ST_SHIFT;
            bit_q <= '0;
          end
        end
        ST_SHIFT: begin
          if (rise_evt && !in_tx) rx_sh_q <= rx_byte[6:0];
          if (fall_evt) begin
            if (bit_q == last_bit) st_q <= ST_TAIL;
            else                   bit_q <= bit_q + BIT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R6
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (bit_q <= last_bit));

  // R5
  rx_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> ({2'b00, rx_lane} < rx_cnt));
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  logic              busy;
  logic              go;
  logic              run;
  logic              rise_evt;
  logic              fall_evt;
  logic              rx_we;
  logic [1:0]        rx_lane;
  logic [7:0]        rx_byte;
  logic [WORD_W-1:0] cmd_q;
  logic [WORD_W-1:0] data_q;
  logic [CNT_W-1:0]  tx_cnt;
  logic [CNT_W-1:0]  rx_cnt;

  spi_eng_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .rx_we(rx_we),
    .rx_lane(rx_lane), .rx_byte(rx_byte), .cmd_q(cmd_q), .data_q(data_q),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .go(go)
  );

  spi_eng_sclk #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk(clk), .rst_n(rst_n), .run(run), .sck(spi_sck),
    .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  spi_eng_frame u_frame (
    .clk(clk), .rst_n(rst_n), .go(go), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .cmd_q(cmd_q), .data_q(data_q), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .miso(spi_miso), .run(run), .busy(busy), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .rx_we(rx_we), .rx_lane(rx_lane), .rx_byte(rx_byte)
  );

  // R7
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (busy && !spi_cs_n));

  // R7
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> !busy);

  // R8
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R3
  mosi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_mosi);
endmodule

// File: tb/test_spi_cmd_engine.sv
`timescale 1ns/1ps
module test_spi_cmd_engine;
  localparam int HD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  logic        spi_sck, spi_mosi, spi_miso, spi_cs_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] slave_bytes [12];
  logic       cap_bits [96];
  int         cap_n = 0;
  int         cs_falls = 0;
  realtime    last_rise = 0.0;
  realtime    prev_rise = 0.0;

  always #2.5 clk = ~clk;

  spi_cmd_engine #(.HALF_DIV(HD)) i_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // flash model: capture MOSI on rising SCLK, present the next MISO bit afterwards
  always @(posedge spi_sck) begin
    if (cap_n < 96) cap_bits[cap_n] = spi_mosi;
    cap_n = cap_n + 1;
    prev_rise = last_rise;
    last_rise = $realtime;
  end

  always @(negedge spi_cs_n) cs_falls = cs_falls + 1;

  always_comb begin
    if (!spi_cs_n && cap_n < 96) begin
      logic [7:0] b;
      b = slave_bytes[cap_n / 8];
      spi_miso = b[3'(7 - (cap_n % 8))];
    end else begin
      spi_miso = 1'b0;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic logic [7:0] exp_tx(input logic [31:0] c, input logic [31:0] d, input int i);
    if (i == 0) return c[7:0];
    if (i < 4)  return 8'(c >> (8 * (4 - i)));
    return 8'(d >> (8 * (i - 4)));
  endfunction

  function automatic int sat(input int v, input int lim);
    return (v > lim) ? lim : v;
  endfunction

  task automatic load_slave(input int seed);
    for (int i = 0; i < 12; i++) slave_bytes[i] = 8'((seed + i * 37) ^ (i * 5));
  endtask

  // one complete frame with checks of its wire image, timing and data result
  task automatic run_frame(input logic [31:0] c, input logic [31:0] d,
                           input int txf, input int rxf, input string tag);
    int txe, rxe;
    logic [31:0] v, expd;
    logic rx_or;
    txe = sat(txf, 8);
    rxe = sat(rxf, 4);
    reg_write(2'd0, c);
    reg_write(2'd1, d);
    cap_n = 0;
    reg_write(2'd2, {23'd0, 1'b1, 4'(rxf), 4'(txf)});
    reg_read(2'd2, v);
    check("R7", {tag, " busy after start"}, {31'd0, v[9]}, 32'd1);
    check("R7", {tag, " cs low after start"}, {31'd0, spi_cs_n}, 32'd0);
    @(posedge spi_cs_n);
    @(negedge clk);
    reg_read(2'd2, v);
    check("R7", {tag, " busy one cycle after cs rise"}, {31'd0, v[9]}, 32'd1);
    @(negedge clk);
    reg_read(2'd2, v);
    check("R7", {tag, " busy cleared"}, {31'd0, v[9]}, 32'd0);
    check("R6", {tag, " sclk rising edges"}, 32'(cap_n), 32'(8 * (txe + rxe)));
    for (int i = 0; i < txe; i++) begin
      logic [7:0] got;
      for (int k = 0; k < 8; k++) got[7 - k] = cap_bits[8 * i + k];
      check("R3", $sformatf("%s tx byte %0d", tag, i), {24'd0, got}, {24'd0, exp_tx(c, d, i)});
    end
    rx_or = 1'b0;
    for (int k = 8 * txe; k < 8 * (txe + rxe); k++) rx_or = rx_or | cap_bits[k];
    check("R5", {tag, " mosi low while receiving"}, {31'd0, rx_or}, 32'd0);
    expd = d;
    for (int j = 0; j < rxe; j++) expd[8 * j +: 8] = slave_bytes[txe + j];
    reg_read(2'd1, v);
    check("R5", {tag, " data word after receive"}, v, expd);
  endtask

  initial begin
    logic [31:0] v;
    load_slave(3);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "cs_n at reset", {31'd0, spi_cs_n}, 32'd1);
    check("R1", "sclk at reset", {31'd0, spi_sck}, 32'd0);
    check("R1", "mosi at reset", {31'd0, spi_mosi}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    reg_read(2'd0, v); check("R1", "command word at reset", v, 32'd0);
    reg_read(2'd1, v); check("R1", "data word at reset", v, 32'd0);
    reg_read(2'd2, v); check("R1", "control word at reset", v, 32'd0);

    // R2: register readback
    reg_write(2'd0, 32'hA1B2C3D4);
    reg_read(2'd0, v); check("R2", "command readback", v, 32'hA1B2C3D4);
    reg_write(2'd1, 32'h0F1E2D3C);
    reg_read(2'd1, v); check("R2", "data readback", v, 32'h0F1E2D3C);
    reg_write(2'd2, 32'h0000_0025);
    reg_read(2'd2, v); check("R2", "control readback", v, 32'h0000_0025);
    reg_read(2'd3, v); check("R2", "unused address", v, 32'd0);

    // R4: clamping of stored counts
    reg_write(2'd2, 32'h0000_009F);
    reg_read(2'd2, v); check("R4", "clamped counts", v, 32'h0000_0048);

    // R3 R5 R6 R7 R8: read-type frame, opcode+address then 4 receive bytes
    load_slave(11);
    run_frame(32'h1234_5603, 32'h0, 4, 4, "read4");
    check("R8", "sclk rise spacing", 32'(int'((last_rise - prev_rise) * 10.0)),
          32'(2 * HD * 50));
    check("R8", "sclk idle low", {31'd0, spi_sck}, 32'd0);

    // R3: program-type frame, all 8 transmit bytes, no receive
    run_frame(32'hABCD_EF02, 32'h1122_3344, 8, 0, "prog8");

    // R5: short receive keeps upper data lanes
    load_slave(77);
    run_frame(32'h0000_0005, 32'hDEAD_BEEF, 1, 2, "status2");

    // R4: out-of-range counts used as 8 and 4
    load_slave(200);
    run_frame(32'h0102_0304, 32'h5566_7788, 15, 9, "clamp");

    // R9: writes while busy are ignored
    begin
      int falls0;
      load_slave(9);
      reg_write(2'd0, 32'hCAFE_0B01);
      reg_write(2'd1, 32'h0);
      cap_n = 0;
      falls0 = cs_falls;
      reg_write(2'd2, 32'h0000_0148);
      reg_write(2'd0, 32'hFFFF_FFFF);
      reg_write(2'd2, 32'h0000_0101);
      @(posedge spi_cs_n);
      repeat (3) @(negedge clk);
      reg_read(2'd0, v); check("R9", "command kept during busy", v, 32'hCAFE_0B01);
      reg_read(2'd2, v); check("R9", "counts kept during busy", v, 32'h0000_0048);
      check("R9", "single frame", 32'(cs_falls - falls0), 32'd1);
      check("R9", "frame length unchanged", 32'(cap_n), 32'd96);
    end

    // R10: start with zero counts
    begin
      int falls0;
      falls0 = cs_falls;
      reg_write(2'd2, 32'h0000_0100);
      reg_read(2'd2, v); check("R10", "no busy on empty start", {31'd0, v[9]}, 32'd0);
      repeat (6) @(negedge clk);
      check("R10", "cs stays high", {31'd0, spi_cs_n}, 32'd1);
      check("R10", "no frame started", 32'(cs_falls - falls0), 32'd0);
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog: got no completion expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule